// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by looking up one word of a flat page table in memory. A requester hands it a virtual address and an access kind (read, write or execute) over a valid/ready handshake. The walker adds the virtual page number, scaled to a word address, to a table base held in an internal register. It issues exactly one read on a simple memory request/response port. It then judges the returned table entry and reports one of three results: a translated physical address, a page fault, or a protection fault.

Pages are 1 KB. The low ten bits of the address pass through unchanged, and the upper bits are replaced by the frame number stored in the entry. The table base is loaded through a separate write strobe. A new base applies only to requests accepted after the edge on which it was written. One walk is in flight at a time. Each result appears as a one-cycle pulse in the cycle after the memory response is taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, `reqReady` is 1, `memReqValid` is 0, `doneValid` is 0 and the table base register holds 0.
- R2: For an accepted request, the walker issues exactly one memory read at address base + 4 × vaddr[31:10] (modulo 2^32). It keeps `memReqValid` high and `memReqAddr` unchanged until `memReqReady` is seen.
- R3: The entry is 32 bits. Bit 31 is valid, bit 30 grants read, bit 29 grants write, bit 28 grants execute, and bits 19:0 hold the frame number. When the entry is valid and the access is permitted, `doneFault` is 0 and `donePaddr` is {entry[19:0], vaddr[9:0]}.
- R4: When entry bit 31 is 0, `doneFault` is 1 (page fault) and `donePaddr` is 0, whatever the rights bits hold.
- R5: The access code is 0 for read, 1 for write and 2 for execute. A valid entry whose matching rights bit is 0 gives `doneFault` 2 (protection fault) with `donePaddr` 0. Access code 3 always gives a protection fault on a valid entry.
- R6: Only one request is handled at a time. `reqReady` is 0 from the acceptance edge until the walk has finished, and no further memory read is issued during that time.
- R7: `doneValid` is high for exactly one cycle, and that cycle immediately follows the edge on which `memRspValid` was taken. `memRspValid` while no read is outstanding has no effect.
- R8: A base write takes effect for requests accepted on later edges. A request accepted on the same edge as the write uses the old base, and a write during a walk does not change that walk's memory address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseWrEn | input | 1 | Load strobe for the table base register |
| baseWrData | input | 32 | New table base byte address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| memReqValid | output | 1 | Table entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the table entry |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Table entry word |
| doneValid | output | 1 | One-cycle result pulse |
| donePaddr | output | 30 | Physical address, 0 on a fault |
| doneFault | output | 2 | 0 none, 1 page fault, 2 protection fault |

## Verification
A table base load and a request acceptance can fall on the same clock edge. A base load can also arrive while a walk is waiting on a stalled memory port. The bench provokes the first by raising `baseWrEn` and `reqValid` in the same cycle. It provokes the second by writing the base while the memory model holds `memReqReady` low for several cycles. In both cases the scoreboard expects the entry address built from the old base, and the request after that one is expected at the new base.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } access_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch request and form entry address
    logic issue;    // memory read being presented
    logic capRsp;   // latch returned entry
    logic present;  // result cycle
  } ptwStrobes_t;

endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W      = 32,
  parameter int VALID_POS  = 31,
  parameter int RIGHTS_POS = 28,
  parameter int PPN_W      = 20,
  parameter int N_KINDS    = 3
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       access,
  output fault_e           fault,
  output logic [PPN_W-1:0] ppn
);

  logic [N_KINDS-1:0] granted;
  logic               kindOk;
  logic               unusedSpare;

  // Rights field is ordered read (top), write, execute (bottom)
  genvar k;
  generate
    for (k = 0; k < N_KINDS; k++) begin : g_right
      assign granted[k] = pte[RIGHTS_POS + (N_KINDS - 1) - k];
    end
  endgenerate

  always_comb begin
    kindOk = 1'b0;
    for (int i = 0; i < N_KINDS; i++) begin
      if (int'(access) == i) kindOk = granted[i];
    end
  end

  always_comb begin
    if (!pte[VALID_POS])  fault = FLT_PAGE;
    else if (!kindOk)     fault = FLT_PROT;
    else                  fault = FLT_NONE;
  end

  assign ppn         = pte[PPN_W-1:0];
  assign unusedSpare = ^pte;

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        doneValid,
  output ptwStrobes_t strb
);

  walkState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (reqValid)    stateNxt = ST_ISSUE;
      ST_ISSUE: if (memReqReady) stateNxt = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNxt = ST_DONE;
      ST_DONE:                   stateNxt = ST_IDLE;
      default:                   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign doneValid   = (state == ST_DONE);

  always_comb begin
    strb         = '0;
    strb.capReq  = reqReady && reqValid;
    strb.issue   = memReqValid;
    strb.capRsp  = (state == ST_WAIT) && memRspValid;
    strb.present = doneValid;
  end

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRsp |=> doneValid); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R2
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && memReqValid)); // R6

endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 30,
  parameter int OFF_W      = 10,
  parameter int MA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int VALID_POS  = 31,
  parameter int RIGHTS_POS = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptwStrobes_t       strb,
  input  logic              baseWrEn,
  input  logic [MA_W-1:0]   baseWrData,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [MA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   donePaddr,
  output logic [1:0]        doneFault
);

  localparam int VPN_W     = VA_W - OFF_W;
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int PTE_SHIFT = $clog2(PTE_W / 8);

  logic [MA_W-1:0]  baseReg;
  logic [MA_W-1:0]  entryAddrQ;
  logic [OFF_W-1:0] offsetQ;
  logic [1:0]       accessQ;
  logic [PTE_W-1:0] pteQ;
  logic [VPN_W-1:0] reqVpn;
  fault_e           chkFault;
  logic [PPN_W-1:0] chkPpn;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         baseReg <= '0;
    else if (baseWrEn) baseReg <= baseWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryAddrQ <= '0;
      offsetQ    <= '0;
      accessQ    <= '0;
    end else if (strb.capReq) begin
      entryAddrQ <= baseReg + (MA_W'(reqVpn) << PTE_SHIFT);
      offsetQ    <= reqVaddr[OFF_W-1:0];
      accessQ    <= reqAccess;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pteQ <= '0;
    else if (strb.capRsp) pteQ <= memRspData;
  end

  ptw_pte_check #(
    .PTE_W     (PTE_W),
    .VALID_POS (VALID_POS),
    .RIGHTS_POS(RIGHTS_POS),
    .PPN_W     (PPN_W),
    .N_KINDS   (3)
  ) chk_i (
    .pte   (pteQ),
    .access(accessQ),
    .fault (chkFault),
    .ppn   (chkPpn)
  );

  assign memReqAddr = entryAddrQ;

  always_comb begin
    donePaddr = '0;
    doneFault = FLT_NONE;
    if (strb.present) begin
      doneFault = chkFault;
      if (chkFault == FLT_NONE) donePaddr = {chkPpn, offsetQ};
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.capReq) |=> (!strb.issue || $stable(memReqAddr))); // R8
  AST_OFFSET_COPIED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.present && doneFault == FLT_NONE) |-> (donePaddr[OFF_W-1:0] == offsetQ)); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.present && doneFault != FLT_NONE) |-> (donePaddr == '0)); // R4
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strb.present |-> (doneFault != 2'd3)); // R5

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 10,
  parameter int MA_W  = 32,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [MA_W-1:0]   baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [MA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              doneValid,
  output logic [PA_W-1:0]   donePaddr,
  output logic [1:0]        doneFault
);

  ptwStrobes_t strb;

  ptw_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .doneValid  (doneValid),
    .strb       (strb)
  );

  ptw_dpath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .OFF_W     (OFF_W),
    .MA_W      (MA_W),
    .PTE_W     (PTE_W),
    .VALID_POS (PTE_W - 1),
    .RIGHTS_POS(PTE_W - 4)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseWrEn  (baseWrEn),
    .baseWrData(baseWrData),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .donePaddr (donePaddr),
    .doneFault (doneFault)
  );

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [29:0] donePaddr;
  logic [1:0]  doneFault;

  always #2 clk = ~clk;  // 250 MHz

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePaddr(donePaddr), .doneFault(doneFault)
  );

  typedef struct {
    logic [31:0] mAddr;
    logic [31:0] pte;
    logic [29:0] paddr;
    logic [1:0]  fault;
    int          stall;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          fails = 0;
  int          cycleCnt = 0;
  int          rspCycle = 0;
  int          memReads = 0;
  int          nReq = 0;
  logic [31:0] curBase = '0;
  logic        injectRsp = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [1:0] expFault(input logic [31:0] pte, input logic [1:0] acc);
    logic ok;
    if (!pte[31]) return 2'd1;
    case (acc)
      2'd0: ok = pte[30];
      2'd1: ok = pte[29];
      2'd2: ok = pte[28];
      default: ok = 1'b0;
    endcase
    return ok ? 2'd0 : 2'd2;
  endfunction

  // Memory model
  initial begin
    forever begin
      @(negedge clk);
      if (injectRsp && !memReqValid) begin
        memRspValid = 1'b1;
        memRspData  = 32'hFFFF_FFFF;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = '0;
        injectRsp   = 1'b0;
      end else if (memReqValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 memory read with no walk expected", 1, 0);
        end else begin
          exp_t cur;
          cur = expQ[0];
          for (int s = 0; s < cur.stall; s++) begin
            check(reqReady == 1'b0, {"R6 reqReady low during walk ", cur.tag}, reqReady, 0);
            @(negedge clk);
          end
          check(memReqValid == 1'b1, {"R2 read held ", cur.tag}, memReqValid, 1);
          check(memReqAddr == cur.mAddr, {"R2/R8 entry address ", cur.tag}, memReqAddr, cur.mAddr);
          memReqReady = 1'b1;
          @(negedge clk);
          memReqReady = 1'b0;
          memReads++;
          check(memReqValid == 1'b0, {"R2 single read ", cur.tag}, memReqValid, 0);
          for (int l = 0; l < cur.lat; l++) @(negedge clk);
          memRspValid = 1'b1;
          memRspData  = cur.pte;
          rspCycle    = cycleCnt;
          @(negedge clk);
          memRspValid = 1'b0;
          memRspData  = '0;
        end
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (doneValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t cur;
          cur = expQ.pop_front();
          check(cycleCnt == rspCycle + 1, {"R7 done timing ", cur.tag}, cycleCnt, rspCycle + 1);
          check(doneFault == cur.fault, {"fault code ", cur.tag}, doneFault, cur.fault);
          check(donePaddr == cur.paddr, {"physical address ", cur.tag}, donePaddr, cur.paddr);
          @(negedge clk);
          check(doneValid == 1'b0, {"R7 done single pulse ", cur.tag}, doneValid, 0);
        end
      end
    end
  end

  task automatic writeBase(input logic [31:0] b);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 1'b0;
    curBase = b;
  endtask

  task automatic doReq(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] pte,
                       input int stall, input int lat, input bit wrSame, input bit wrMid,
                       input logic [31:0] newBase, input string tag);
    exp_t e;
    e.mAddr = curBase + (32'(va[31:10]) << 2);
    e.pte   = pte;
    e.fault = expFault(pte, acc);
    e.paddr = (e.fault == 2'd0) ? {pte[19:0], va[9:0]} : 30'd0;
    e.stall = stall;
    e.lat   = lat;
    e.tag   = tag;
    expQ.push_back(e);
    nReq++;
    @(negedge clk);
    check(reqReady == 1'b1, {"R6 ready before request ", tag}, reqReady, 1);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc;
    if (wrSame) begin baseWrEn = 1'b1; baseWrData = newBase; end
    @(negedge clk);
    reqValid = 1'b0;
    baseWrEn = 1'b0;
    if (wrSame) curBase = newBase;
    if (wrMid) begin
      baseWrEn = 1'b1; baseWrData = newBase;
      @(negedge clk);
      baseWrEn = 1'b0;
      curBase = newBase;
    end
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset reqReady", reqReady, 1);
    check(memReqValid == 1'b0, "R1 reset memReqValid", memReqValid, 0);
    check(doneValid == 1'b0, "R1 reset doneValid", doneValid, 0);

    // R1 base at zero, R3 read granted
    doReq(32'h0001_2C37, 2'd0, 32'hC00A_BCDE, 0, 0, 0, 0, 0, "R1 R3 read ok base0");
    writeBase(32'h0010_0000);
    doReq(32'hFFFF_FFFF, 2'd1, 32'hA001_2345, 2, 3, 0, 0, 0, "R3 write ok top vpn");
    doReq(32'h0040_0155, 2'd2, 32'h900F_FFFF, 1, 0, 0, 0, 0, "R3 exec ok");
    // R4 page faults
    doReq(32'h1234_5678, 2'd0, 32'h700F_0F0F, 0, 1, 0, 0, 0, "R4 invalid all rights");
    doReq(32'h0000_0000, 2'd3, 32'h0000_0001, 0, 0, 0, 0, 0, "R4 invalid code3");
    // R5 protection faults
    doReq(32'h0000_1400, 2'd0, 32'hB000_0111, 0, 0, 0, 0, 0, "R5 read denied");
    doReq(32'h0000_1800, 2'd1, 32'hC000_0222, 1, 2, 0, 0, 0, "R5 write denied");
    doReq(32'h0000_1C00, 2'd2, 32'hE000_0333, 0, 0, 0, 0, 0, "R5 exec denied");
    doReq(32'h0000_2000, 2'd3, 32'hF000_0444, 0, 0, 0, 0, 0, "R5 code3 denied");
    // R8 base write in same cycle as acceptance, then mid-walk
    doReq(32'h00AB_C3FF, 2'd0, 32'hC000_0555, 0, 0, 1, 0, 32'h2000_0000, "R8 same-edge old base");
    doReq(32'h00AB_C3FF, 2'd0, 32'hC000_0666, 0, 0, 0, 0, 0, "R8 new base applies");
    doReq(32'h0300_0800, 2'd1, 32'hE000_0777, 4, 0, 0, 1, 32'h0300_0000, "R8 mid-walk write");
    doReq(32'h0300_0800, 2'd1, 32'hE000_0888, 0, 0, 0, 0, 0, "R8 after mid-walk");

    // R7 response while idle is ignored
    @(negedge clk);
    injectRsp = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(doneValid == 1'b0, "R7 stray response no done", doneValid, 0);
      check(reqReady == 1'b1, "R7 stray response stays idle", reqReady, 1);
    end
    doReq(32'h0000_07FF, 2'd0, 32'hC00F_FFFF, 0, 5, 0, 0, 0, "R7 R3 after stray response");

    check(memReads == nReq, "R2 one read per request", memReads, nReq);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule